// File: doc/BRIEF.md
# Lock-Bit Protection Controller

This block guards an on-chip code memory with three sticky protection bits. Each bit starts clear and can only be set. The bits map to four cumulative protection levels. Each level removes one more capability. In order, these are: programming the memory, reading back its contents for verification, executing from external code space, and letting external code read internal memory as table data. The block turns the current level into one enable signal per capability. Memory, sequencing and fetch logic use these enables.

The stored bits are reloaded from the non-volatile array (`nv_lock`) on every cycle that reset is held. New bits are set with a write strobe and a selector. Once the first bit is set, a strobe is honoured only if it raises the protection. On the same reset cycles, the block also captures the level on the external-access pin. While the first bit is set, it compares the captured level with the live pin and raises a fault when they differ. The bit values are never presented on any port. They can only be observed through the enables they drive.

Top module: `lockbit_guard`

## Requirements
- R1: While `rst` is high (synchronous, active high), the stored bits take the value of `nv_lock` at each rising clock edge. Bit 0 is the first lock bit (L1), bit 1 is L2 and bit 2 is L3.
- R2: Stored bits never clear outside reset. A strobe (`lock_wr` high at a rising edge) with `lock_sel` = 1, 2 or 3 sets L1, L2 or L3 respectively. `lock_sel` = 0 changes nothing.
- R3: The level is 1 when L1 is clear, whatever L2 and L3 hold. It is 2 when only L1 of the first two is set. It is 3 when L1 and L2 are set but L3 is clear. It is 4 when all three are set. L3 set without L2 therefore still gives level 2.
- R4: `prog_en` is high only at level 1.
- R5: `verify_en` is high at levels 1 and 2. `ext_exec_en` is high at levels 1 to 3.
- R6: `table_rd_en` is low exactly when the level is 2 or higher and `fetch_ext` is high.
- R7: The EA latch takes `ea_pin` at every rising edge with `rst` high. Outside reset, it holds its value whatever the pin does.
- R8: `ea_fault` is high exactly when L1 is set and the latched EA differs from the live `ea_pin`. It follows the pin without a clock edge.
- R9: When L1 is set, a strobe is ignored unless the selected bit lies above the highest bit already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads bits and samples EA |
| nv_lock | input | 3 | Lock bits from the non-volatile array |
| ea_pin | input | 1 | Live external-access pin level |
| lock_wr | input | 1 | Lock-bit program strobe |
| lock_sel | input | 2 | Bit selector: 1..3 picks L1..L3, 0 picks none |
| fetch_ext | input | 1 | Current fetch executes from external code space |
| prog_en | output | 1 | Code-memory programming allowed |
| verify_en | output | 1 | Verify read-back allowed |
| ext_exec_en | output | 1 | External execution allowed |
| table_rd_en | output | 1 | Table read of internal memory allowed for this fetch |
| ea_fault | output | 1 | Latched EA disagrees with live pin while L1 set |

## Verification
The bench targets the irregular pattern where L3 is set without L2. A decoder that counted set bits would report level 3 and drop `verify_en`. A strobe aimed at L2 beneath an already-set L3 checks that a design accepting every strobe would wrongly reach level 4. The pin is toggled outside reset after captures at both polarities. A latch that kept sampling would hide the fault, and a compare that was not gated by L1 would flag a fault at level 1. A selector value of zero is also driven, to catch a decoder that maps it onto L1.

// File: rtl/lockbit_guard.sv
module lockbit_guard #(
  parameter int NLOCK = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLOCK-1:0] nv_lock,
  input  logic             ea_pin,
  input  logic             lock_wr,
  input  logic [1:0]       lock_sel,
  input  logic             fetch_ext,
  output logic             prog_en,
  output logic             verify_en,
  output logic             ext_exec_en,
  output logic             table_rd_en,
  output logic             ea_fault
);

  logic [NLOCK-1:0] lock_q;
  logic             ea_q;
  logic [NLOCK-1:0] sel_bit;
  logic [NLOCK-1:0] above;
  logic             accept;

  // one-hot of the selected bit; zero selects none
  always_comb begin
    sel_bit = '0;
    for (int i = 0; i < NLOCK; i++)
      if (int'(lock_sel) == i + 1) sel_bit[i] = 1'b1;
  end

  // positions strictly above the highest set bit
  always_comb begin
    above = '1;
    for (int i = 0; i < NLOCK; i++)
      if (lock_q[i]) above = '1 << (i + 1);
  end

  assign accept = lock_wr && (sel_bit != '0) &&
                  (!lock_q[0] || ((sel_bit & above) != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= nv_lock;
      ea_q   <= ea_pin;
    end else if (accept) begin
      lock_q <= lock_q | sel_bit;
    end
  end

  assign prog_en     = !lock_q[0];
  assign verify_en   = !(lock_q[0] && lock_q[1]);
  assign ext_exec_en = !(&lock_q);
  assign table_rd_en = !(lock_q[0] && fetch_ext);
  assign ea_fault    = lock_q[0] && (ea_q != ea_pin);

endmodule

// File: rtl/lockbit_guard_chk.sv
module lockbit_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] lock_q,
  input logic       ea_q,
  input logic       lock_wr,
  input logic       fetch_ext,
  input logic       prog_en,
  input logic       verify_en,
  input logic       ext_exec_en,
  input logic       table_rd_en,
  input logic       ea_fault
);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  assert_ea_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(ea_q));

  assert_cumulative_R5: assert property (@(posedge clk) disable iff (rst)
    (prog_en |-> verify_en) and (verify_en || ext_exec_en || !prog_en));

  assert_exec_before_verify_R5: assert property (@(posedge clk) disable iff (rst)
    !ext_exec_en |-> !verify_en);

  assert_table_block_R6: assert property (@(posedge clk) disable iff (rst)
    (!prog_en && fetch_ext) |-> !table_rd_en);

  assert_fault_gate_R8: assert property (@(posedge clk) disable iff (rst)
    prog_en |-> !ea_fault);

  assert_top_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (lock_wr && lock_q[0] && lock_q[2]) |=> $stable(lock_q));

endmodule

bind lockbit_guard lockbit_guard_chk u_chk (
  .clk(clk), .rst(rst), .lock_q(lock_q), .ea_q(ea_q), .lock_wr(lock_wr),
  .fetch_ext(fetch_ext), .prog_en(prog_en), .verify_en(verify_en),
  .ext_exec_en(ext_exec_en), .table_rd_en(table_rd_en), .ea_fault(ea_fault)
);

// File: tb/lockbit_guard_test.sv
`timescale 1ns/1ps
module lockbit_guard_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] nv_lock = 3'b000;
  logic       ea_pin = 1'b0;
  logic       lock_wr = 1'b0;
  logic [1:0] lock_sel = 2'd0;
  logic       fetch_ext = 1'b0;
  logic       prog_en, verify_en, ext_exec_en, table_rd_en, ea_fault;

  always #2.5 clk = ~clk;

  lockbit_guard uut (
    .clk(clk), .rst(rst), .nv_lock(nv_lock), .ea_pin(ea_pin),
    .lock_wr(lock_wr), .lock_sel(lock_sel), .fetch_ext(fetch_ext),
    .prog_en(prog_en), .verify_en(verify_en), .ext_exec_en(ext_exec_en),
    .table_rd_en(table_rd_en), .ea_fault(ea_fault)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [2:0] m_lock;
  logic       m_ea;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  event       sample_ev;

  function automatic logic [4:0] model_out(logic [2:0] m, logic lat, logic pin, logic fx);
    logic lvl2, lvl3, lvl4;
    lvl2 = m[0];
    lvl3 = m[0] && m[1];
    lvl4 = m[0] && m[1] && m[2];
    return {!lvl2, !lvl3, !lvl4, !(lvl2 && fx), lvl2 && (lat != pin)};
  endfunction

  function automatic bit model_accept(logic [2:0] m, logic [1:0] sel);
    int top;
    if (sel == 2'd0) return 0;
    if (!m[0]) return 1;
    top = m[2] ? 2 : (m[1] ? 1 : 0);
    return (int'(sel) - 1) > top;
  endfunction

  always begin
    @(sample_ev);
    while (exp_q.size() > 0) begin
      logic [4:0] e;
      logic [4:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {prog_en, verify_en, ext_exec_en, table_rd_en, ea_fault};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: {prog,verify,exec,table,fault} actual=%b expected=%b", t, a, e);
      end
    end
  end

  task automatic do_reset(input logic [2:0] nv, input logic ea_first, input logic ea_last);
    @(negedge clk);
    rst = 1'b1; lock_wr = 1'b0; nv_lock = nv; ea_pin = ea_first;
    @(negedge clk);
    ea_pin = ea_last;
    @(negedge clk);
    rst = 1'b0;
    m_lock = nv;
    m_ea = ea_last;
  endtask

  task automatic step(input logic wr, input logic [1:0] sel, input logic pin,
                      input logic fx, input string tag);
    @(negedge clk);
    lock_wr = wr; lock_sel = sel; ea_pin = pin; fetch_ext = fx;
    if (wr && model_accept(m_lock, sel)) m_lock = m_lock | (3'b001 << (int'(sel) - 1));
    @(posedge clk);
    #1;
    exp_q.push_back(model_out(m_lock, m_ea, pin, fx));
    tag_q.push_back(tag);
    ->sample_ev;
    #0.5;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reload from nv array, level 1
    do_reset(3'b000, 1'b0, 1'b1);
    step(0, 0, 1, 0, "R1 reset state level 1");
    step(0, 0, 0, 1, "R6 level 1 table read with external fetch");
    step(0, 0, 0, 0, "R8 no fault while L1 clear");
    // R2: selector zero changes nothing
    step(1, 0, 1, 1, "R2 selector zero ignored");
    step(1, 1, 1, 0, "R2 set L1 -> R4 level 2");
    step(0, 0, 1, 1, "R6 level 2 blocks table read");
    step(0, 0, 0, 0, "R8 fault when pin differs from latch");
    step(0, 0, 1, 0, "R7 latch held outside reset");
    step(1, 1, 1, 0, "R9 strobe of L1 ignored");
    step(1, 3, 1, 0, "R3 L3 without L2 still level 2");
    step(1, 2, 1, 0, "R9 L2 below L3 ignored");
    step(0, 0, 1, 0, "R5 verify still enabled");
    // R1: reload to level 3, EA latched at last reset cycle
    do_reset(3'b011, 1'b1, 1'b0);
    step(0, 0, 0, 0, "R1 reload level 3 R5 verify off");
    step(0, 0, 1, 1, "R8 fault with pin high R6 blocked");
    step(1, 3, 0, 0, "R9 raise to L3 -> R5 level 4");
    step(1, 1, 0, 0, "R9 lower strobe at level 4 ignored");
    // R3: L1 clear with others set is level 1
    do_reset(3'b110, 1'b0, 1'b0);
    step(0, 0, 1, 1, "R3 L1 clear means level 1");
    step(1, 1, 1, 0, "R2 set L1 -> level 4 R8 fault");
    step(0, 0, 0, 0, "R7 fault clears when pin matches");
    do_reset(3'b001, 1'b1, 1'b1);
    step(0, 0, 1, 0, "R1 reload level 2 no fault");
    step(0, 0, 0, 0, "R8 fault after pin drop");
    step(1, 2, 0, 1, "R9 L2 above L1 accepted R6");
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule